// File: doc/BRIEF.md
# Prioritised Edge and Change Interrupt Controller

This block collects interrupt events from five sources and turns them into two processor request lines, one for each priority level, and a wake-up line. The sources are three external pins detected on edges, an overflow pulse from a timer, and a change detector that watches the upper nibble of an 8-bit input port. Each source has a sticky flag, an enable bit and a priority bit. The priority bit is fixed at high for pin 0. A small register bus reads and writes these bits. The timer counter is outside the block: a one-cycle pulse on `tmr_ovf_i` marks the cycle in which the counter wraps from all ones to zero, whether it runs as 8 or 16 bits.

The external pins are asynchronous to the clock. Each pin has its own polarity bit, and its edges are found after a two-flop synchronizer. The port nibble is also synchronized. It is compared with a reference that the block reloads each time software reads the port register, so a read followed by a flag clear ends the change condition. The two request lines are gated by a global enable. The wake-up line is not gated by it and depends only on the flags, the per-source enables and the sleep indication.

Top module: `irq_ctrl`

## Requirements
- R1: Pin p (p = 0..2) is flagged only on the edge its polarity bit selects. The polarity bit is CTRL bit p+1 and sets rising when 1 and falling when 0. The edge of the opposite direction leaves the flag clear.
- R2: Flags sit at FLAGS (address 3), with bits 0..2 for pins 0..2, bit 3 for the timer and bit 4 for the port change. A flag stays set until software writes a 0 to its bit. Writing a 1 to a flag bit has no effect.
- R3: A flag whose enable bit is clear raises neither request. The enables are at ENABLE (address 1), with bits 0..4 in the same order as the flags.
- R4: Pin 0 always goes to the high-priority request. For sources 1..4, PRIO (address 2) bits 1..4 route the source to the high request when 1 and to the low request when 0. PRIO bit 0 always reads as 1.
- R5: Both request outputs are low whenever the global enable (CTRL bit 0) is 0.
- R6: `wake_o` is high exactly when `sleep_i` is high and at least one source is both flagged and enabled. The global enable does not affect it.
- R7: A one-cycle pulse on `tmr_ovf_i` sets FLAGS bit 3 at the next clock edge.
- R8: A change on synchronized port bits 7..4 against the reference sets FLAGS bit 4. Changes on bits 3..0 are ignored. A read of PORT (address 4) returns the synchronized port and reloads the reference.
- R9: Changing a polarity bit while the pin is held at a steady level does not set that pin's flag.
- R10: If a flag is written clear in the same cycle that a new event arrives for that source, the flag stays set.
- R11: After reset, CTRL, ENABLE and FLAGS read 0 and PRIO reads 0x01. Register reads are combinational from `bus_addr_i` while `bus_rd_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_pin_i | input | 3 | External interrupt pins (asynchronous) |
| tmr_ovf_i | input | 1 | Timer wrap pulse, one cycle |
| port_i | input | 8 | Input port; bits 7..4 are watched for change |
| sleep_i | input | 1 | Processor is sleeping |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data |
| irq_hi_o | output | 1 | High-priority interrupt request |
| irq_lo_o | output | 1 | Low-priority interrupt request |
| wake_o | output | 1 | Wake-up request |

## Verification
The assertions check on every cycle that flags are sticky, that an event always sets its flag even while a clear is being written, that a detected edge needs a change on the synchronized pin, that a port read leaves no stale change, and that the gating by global enable, sleep and the fixed priority of pin 0 holds. Other behaviour can only be shown by the bench's scenarios. These include the choice between rising and falling edges for each pin, masking of the low port nibble, the absence of a false flag when polarity is rewritten, the register map, and the full sweep over enables, priorities, global enable and sleep in which each request level is compared with a value computed arithmetically.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned N_PIN   = 3;
  localparam int unsigned N_SRC   = N_PIN + 2;
  localparam int unsigned SRC_TMR = N_PIN;
  localparam int unsigned SRC_CHG = N_PIN + 1;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned DATA_W  = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_EN   = 3'd1,
    REG_PRIO = 3'd2,
    REG_FLAG = 3'd3,
    REG_PORT = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_i,
  input  logic rise_i,
  output logic pulse_o
);
  logic prev_q;

  // prev tracks every cycle, including a polarity write, so no stale compare
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= s_i;
  end

  assign pulse_o = rise_i ? (s_i & ~prev_q) : (~s_i & prev_q);

  AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> !$stable(s_i)); // R9
endmodule

// File: rtl/irq_chg_det.sv
module irq_chg_det #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] nib_i,
  input  logic         reload_i,
  output logic         chg_o
);
  logic [W-1:0] ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ref_q <= '0;
    else if (reload_i) ref_q <= nib_i;
  end

  assign chg_o = (nib_i != ref_q);

  AST_RELOAD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> (chg_o == !$stable(nib_i))); // R8
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [PORT_W-1:0]    port_i,
  input  logic [N_SRC-1:0]     evt_i,
  output logic                 glb_en_o,
  output logic [N_PIN-1:0]     rise_o,
  output logic [N_SRC-1:0]     en_o,
  output logic [N_SRC-1:0]     prio_o,
  output logic [N_SRC-1:0]     flag_o
);
  logic               glb_q;
  logic [N_PIN-1:0]   rise_q;
  logic [N_SRC-1:0]   en_q;
  logic [N_SRC-1:1]   prio_q;
  logic [N_SRC-1:0]   flag_q;
  logic [N_SRC-1:0]   clr;
  logic               wr_ctrl, wr_en, wr_prio, wr_flag;

  assign wr_ctrl = wr_i && (addr_i == REG_CTRL);
  assign wr_en   = wr_i && (addr_i == REG_EN);
  assign wr_prio = wr_i && (addr_i == REG_PRIO);
  assign wr_flag = wr_i && (addr_i == REG_FLAG);
  assign clr     = wr_flag ? ~wdata_i[N_SRC-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_q  <= 1'b0;
      rise_q <= '0;
      en_q   <= '0;
      prio_q <= '0;
      flag_q <= '0;
    end else begin
      if (wr_ctrl) begin
        glb_q  <= wdata_i[0];
        rise_q <= wdata_i[N_PIN:1];
      end
      if (wr_en)   en_q   <= wdata_i[N_SRC-1:0];
      if (wr_prio) prio_q <= wdata_i[N_SRC-1:1];
      // a new event outranks a clear in the same cycle
      flag_q <= (flag_q & ~clr) | evt_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        REG_CTRL: rdata_o = DATA_W'({rise_q, glb_q});
        REG_EN:   rdata_o = DATA_W'(en_q);
        REG_PRIO: rdata_o = DATA_W'({prio_q, 1'b1});
        REG_FLAG: rdata_o = DATA_W'(flag_q);
        REG_PORT: rdata_o = DATA_W'(port_i);
        default:  rdata_o = '0;
      endcase
    end
  end

  assign glb_en_o = glb_q;
  assign rise_o   = rise_q;
  assign en_o     = en_q;
  assign prio_o   = {prio_q, 1'b1};
  assign flag_o   = flag_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_chk
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && !clr[i]) |=> flag_q[i]); // R2
    AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] |=> flag_q[i]); // R10
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned CHG_LO      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_PIN-1:0]     ext_pin_i,
  input  logic                 tmr_ovf_i,
  input  logic [PORT_W-1:0]    port_i,
  input  logic                 sleep_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic                 bus_wr_i,
  input  logic                 bus_rd_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  output logic                 irq_hi_o,
  output logic                 irq_lo_o,
  output logic                 wake_o
);
  localparam int unsigned CHG_W = PORT_W - CHG_LO;

  logic [N_PIN-1:0]  pin_s;
  logic [PORT_W-1:0] port_s;
  logic [N_PIN-1:0]  pin_evt;
  logic              chg;
  logic [N_SRC-1:0]  evt;
  logic              glb_en;
  logic [N_PIN-1:0]  rise;
  logic [N_SRC-1:0]  en, prio, flag, req;
  logic              reload;

  irq_sync #(.W(N_PIN), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk_i, .rst_ni, .d_i(ext_pin_i), .q_o(pin_s)
  );

  irq_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_port_sync (
    .clk_i, .rst_ni, .d_i(port_i), .q_o(port_s)
  );

  for (genvar p = 0; p < N_PIN; p++) begin : g_pin
    irq_edge_det u_edge (
      .clk_i, .rst_ni, .s_i(pin_s[p]), .rise_i(rise[p]), .pulse_o(pin_evt[p])
    );
  end

  assign reload = bus_rd_i && (bus_addr_i == REG_PORT);

  irq_chg_det #(.W(CHG_W)) u_chg (
    .clk_i, .rst_ni, .nib_i(port_s[PORT_W-1:CHG_LO]), .reload_i(reload), .chg_o(chg)
  );

  assign evt = {chg, tmr_ovf_i, pin_evt};

  irq_regs #(.PORT_W(PORT_W)) u_regs (
    .clk_i, .rst_ni,
    .addr_i(bus_addr_i), .wr_i(bus_wr_i), .rd_i(bus_rd_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .port_i(port_s), .evt_i(evt),
    .glb_en_o(glb_en), .rise_o(rise), .en_o(en), .prio_o(prio), .flag_o(flag)
  );

  assign req      = flag & en;
  assign irq_hi_o = glb_en & |(req & prio);
  assign irq_lo_o = glb_en & |(req & ~prio);
  assign wake_o   = sleep_i & |req;

  AST_GLB_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en |-> (!irq_hi_o && !irq_lo_o)); // R5
  AST_PIN0_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_en && flag[0] && en[0]) |-> irq_hi_o); // R4
  AST_WAKE_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> sleep_i); // R6
  AST_DISABLED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> (!irq_hi_o && !irq_lo_o && !wake_o)); // R3
endmodule

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] ext_pin_i = '0;
  logic       tmr_ovf_i = 1'b0;
  logic [7:0] port_i = '0;
  logic       sleep_i = 1'b0;
  logic [2:0] bus_addr_i = '0;
  logic       bus_wr_i = 1'b0;
  logic       bus_rd_i = 1'b0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic       irq_hi_o, irq_lo_o, wake_o;

  int checks = 0;
  int failures = 0;

  always #5 clk_i = ~clk_i;

  irq_ctrl dut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr_i = a; bus_rd_i = 1'b1;
    #1 d = bus_rdata_o;
    @(negedge clk_i);
    bus_rd_i = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(1);

    // R11 reset values and readback
    chk_reg("R11 ctrl reset", 3'd0, 8'h00);
    chk_reg("R11 en reset", 3'd1, 8'h00);
    chk_reg("R11 prio reset", 3'd2, 8'h01);
    chk_reg("R11 flag reset", 3'd3, 8'h00);
    check("R11 outputs reset", {5'b0, irq_hi_o, irq_lo_o, wake_o}, 8'h00);
    wr(3'd0, 8'h0F); chk_reg("R11 ctrl rb", 3'd0, 8'h0F);
    wr(3'd1, 8'hFF); chk_reg("R11 en rb", 3'd1, 8'h1F);
    wr(3'd2, 8'hFF); chk_reg("R11 prio rb", 3'd2, 8'h1F);
    wr(3'd2, 8'h00); chk_reg("R4 prio bit0 fixed", 3'd2, 8'h01);
    wr(3'd1, 8'h00); wr(3'd0, 8'h00);

    // R1 edge polarity per pin
    for (int p = 0; p < 3; p++) begin
      for (int pol = 0; pol < 2; pol++) begin
        wr(3'd0, 8'(pol << (p + 1)));
        ext_pin_i[p] = pol[0]; wait_cyc(4);
        wr(3'd3, 8'h00);
        ext_pin_i[p] = ~pol[0]; wait_cyc(4);
        chk_reg("R1 wrong edge ignored", 3'd3, 8'h00);
        ext_pin_i[p] = pol[0]; wait_cyc(4);
        chk_reg("R1 selected edge flags", 3'd3, 8'(1 << p));
        ext_pin_i[p] = 1'b0; wait_cyc(4);
        wr(3'd3, 8'h00);
      end
    end

    // R9 polarity rewrite with steady pin
    wr(3'd0, 8'h00);
    ext_pin_i[0] = 1'b1; wait_cyc(4);
    wr(3'd3, 8'h00);
    wr(3'd0, 8'h02); wait_cyc(4);
    wr(3'd0, 8'h00); wait_cyc(4);
    chk_reg("R9 no false edge", 3'd3, 8'h00);
    ext_pin_i[0] = 1'b0; wait_cyc(4);
    chk_reg("R9 detector still live", 3'd3, 8'h01);
    wr(3'd3, 8'h00);

    // R7 timer pulse
    tmr_ovf_i = 1'b1; @(negedge clk_i); tmr_ovf_i = 1'b0;
    chk_reg("R7 timer flag", 3'd3, 8'h08);
    wr(3'd3, 8'h00);

    // R10 event beats clear
    tmr_ovf_i = 1'b1; bus_addr_i = 3'd3; bus_wdata_i = 8'h00; bus_wr_i = 1'b1;
    @(negedge clk_i);
    tmr_ovf_i = 1'b0; bus_wr_i = 1'b0;
    chk_reg("R10 event wins", 3'd3, 8'h08);
    wr(3'd3, 8'h00);

    // R8 port change
    port_i = 8'h0F; wait_cyc(4);
    chk_reg("R8 low nibble ignored", 3'd3, 8'h00);
    port_i = 8'h4F; wait_cyc(4);
    chk_reg("R8 high nibble flags", 3'd3, 8'h10);
    wr(3'd3, 8'h00);
    chk_reg("R8 condition persists", 3'd3, 8'h10);
    chk_reg("R8 port read value", 3'd4, 8'h4F);
    wr(3'd3, 8'h00); wait_cyc(2);
    chk_reg("R8 cleared after read", 3'd3, 8'h00);

    // set every flag for the sweep
    ext_pin_i = 3'b111; wait_cyc(4);
    ext_pin_i = 3'b000; wait_cyc(4);
    tmr_ovf_i = 1'b1; @(negedge clk_i); tmr_ovf_i = 1'b0;
    port_i = 8'hCF; wait_cyc(4);
    chk_reg("R2 all flags set", 3'd3, 8'h1F);

    // R3 R4 R5 R6 sweep over enables, priorities, global enable, sleep
    for (int e = 0; e < 32; e++) begin
      for (int pr = 0; pr < 16; pr++) begin
        for (int g = 0; g < 2; g++) begin
          wr(3'd1, 8'(e));
          wr(3'd2, 8'(pr << 1));
          wr(3'd0, 8'(g));
          for (int s = 0; s < 2; s++) begin
            logic [4:0] pf;
            logic eh, el, ew;
            sleep_i = s[0];
            #1;
            pf = {pr[3:0], 1'b1};
            eh = g[0] && ((e[4:0] & pf) != 0);
            el = g[0] && ((e[4:0] & ~pf) != 0);
            ew = s[0] && (e[4:0] != 0);
            check("R3 R4 R5 R6 request levels", {5'b0, irq_hi_o, irq_lo_o, wake_o},
                  {5'b0, eh, el, ew});
          end
          sleep_i = 1'b0;
        end
      end
    end
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);

    // R2 selective clear, write-one ignored
    rd(3'd4, v);
    wr(3'd3, 8'h1E); chk_reg("R2 clear bit0 only", 3'd3, 8'h1E);
    wr(3'd3, 8'h1F); chk_reg("R2 writing one no effect", 3'd3, 8'h1E);
    wr(3'd3, 8'h00); chk_reg("R2 clear all", 3'd3, 8'h00);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule